// File: doc/BRIEF.md
# Test Access Port Controller with Secure Instruction Filter

This block is a boundary-scan test access port controller. It follows the
serial test mode select line on every rising edge of the test clock through
the sixteen standard controller states. It holds a 10-bit instruction register,
a one-bit bypass register and a 32-bit device identification register. It
drives the serial test output on the falling edge of the test clock and tells
the pads when that output must be driven.

The boundary-scan cell chain is outside the block. The block gives it capture,
shift and update strobes while a boundary instruction is active. It takes the
chain's serial output back through `bsr_tdo`. It also raises one request to
drive the chain's values onto the pins and another to float every device pin.

When `secure_en` is high, only four instructions are allowed: sample/preload,
bypass, extest and device identification. Every other loaded code, the
pin-float code included, behaves as bypass. Unknown codes also behave as bypass
when secure mode is off.

Top module: `jtag_tap_secure`

## Requirements
- R1: When `trst_n` is low at a rising `tck` edge, the controller enters Test-Logic-Reset and the active instruction becomes device identification (code 10'b00_0000_0110).
- R2: Five rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the instruction becomes device identification.
- R3: In Capture-IR the instruction shift register loads 10'b00_0000_0001. In Shift-IR it shifts one bit per `tck`, least significant bit first, with `tdi` entering at bit 9.
- R4: The active instruction and the control outputs it decodes change only on leaving Update-IR or in Test-Logic-Reset. Shifting a new code does not disturb them.
- R5: The instruction codes are: bypass 10'h3FF, pin float 10'h00B, extest 10'h00F, sample/preload 10'h005, device identification 10'h006. Any other code selects the bypass register.
- R6: While `secure_en` is high, the pin-float code selects bypass and `highz_en` stays low. The other four codes keep their normal meaning.
- R7: `tdo` changes only on falling `tck` edges. `tdo_oe` is high exactly while the controller is in Shift-DR or Shift-IR.
- R8: In Capture-DR the bypass register loads 0. Through bypass, `tdo` repeats `tdi` one `tck` later.
- R9: Device identification captures the `ID_VALUE` parameter and shifts it out over 32 bits, least significant bit first.
- R10: With the pin-float instruction active and secure mode off, `highz_en` is high and the bypass register sits between `tdi` and `tdo`.
- R11: `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR only while extest or sample/preload is active. `extest_en` is high only while extest is active. During a boundary data scan `tdo` follows `bsr_tdo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low controller reset, sampled on rising `tck` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| secure_en | input | 1 | Restricts the allowed instructions to four |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| extest_en | output | 1 | Drive boundary-cell values onto the pins |
| highz_en | output | 1 | Float all device I/O |

## Verification
The assertions assume that `trst_n` is held low for at least one rising and one
falling `tck` edge before any check runs. They also assume that `tms`, `tdi` and
`secure_en` are stable around each rising edge. The bench holds reset for
several cycles. It changes every input two nanoseconds after a falling edge, and
it changes `secure_en` only while the controller is idle in Run-Test/Idle. The
sweep loads every one of the 1024 codes with secure mode off and again with it
on. For each code it predicts the scanned-out data, the strobe counts and the
pin requests from the encoding table.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the test access port: controller states, instruction codes
// and the data-register selection. Assumes a 10-bit instruction register.
package jtag_tap_pkg;

    localparam int IR_W = 10;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SH_DR    = 4'd4,
        ST_EX1_DR   = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EX2_DR   = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SH_IR    = 4'd11,
        ST_EX1_IR   = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EX2_IR   = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_t;

    typedef enum logic [1:0] {
        DSEL_BYPASS = 2'd0,
        DSEL_ID     = 2'd1,
        DSEL_BSR    = 2'd2
    } dr_sel_t;

    localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;
    localparam logic [IR_W-1:0] OP_FLOAT  = 10'h00B;
    localparam logic [IR_W-1:0] OP_EXTEST = 10'h00F;
    localparam logic [IR_W-1:0] OP_SAMPLE = 10'h005;
    localparam logic [IR_W-1:0] OP_IDENT  = 10'h006;

endpackage

// File: rtl/jtag_tap_fsm.sv
// Sixteen-state test access port controller. Moves on each rising tck according
// to tms. Assumes trst_n is synchronous to tck and active low.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;
    logic [2:0] ones_run;

    // Next-state function of the standard controller graph.
    always_comb begin
        unique case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EX1_DR   : ST_SH_DR;
            ST_SH_DR:    nxt = tms ? ST_EX1_DR   : ST_SH_DR;
            ST_EX1_DR:   nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EX2_DR   : ST_PAUSE_DR;
            ST_EX2_DR:   nxt = tms ? ST_UPD_DR   : ST_SH_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   nxt = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EX1_IR   : ST_SH_IR;
            ST_SH_IR:    nxt = tms ? ST_EX1_IR   : ST_SH_IR;
            ST_EX1_IR:   nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EX2_IR   : ST_PAUSE_IR;
            ST_EX2_IR:   nxt = tms ? ST_UPD_IR   : ST_SH_IR;
            default:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // Run length of consecutive tms-high edges, saturating at five (checker aid).
    always_ff @(posedge tck) begin
        if (!trst_n || !tms) ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET)); // R2
    AST_RESET_ENTRY: assert property (@(posedge tck)
        (!trst_n) |=> (state == ST_RESET)); // R1

endmodule

// File: rtl/jtag_tap_ir.sv
// Instruction shift and hold registers, decode and secure-mode filter.
// Assumes secure_en changes only while no scan is in progress.
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  logic       secure_en,
    output logic       ir_lsb,
    output dr_sel_t    dsel,
    output logic       highz_en,
    output logic       extest_en
);
    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    logic            admitted;

    // Instruction shift register: capture pattern, then shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= CAP_PAT;
        else if (state == ST_CAP_IR) ir_sr <= CAP_PAT;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: identification in reset, new code on Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) ir_q <= OP_IDENT;
        else if (state == ST_UPD_IR)      ir_q <= ir_sr;
    end

    // Secure filter: which codes may take effect.
    always_comb begin
        admitted = !secure_en || ir_q == OP_SAMPLE || ir_q == OP_BYPASS ||
                   ir_q == OP_EXTEST || ir_q == OP_IDENT;
    end

    // Decode of the admitted instruction; anything else behaves as bypass.
    always_comb begin
        dsel      = DSEL_BYPASS;
        highz_en  = 1'b0;
        extest_en = 1'b0;
        if (admitted) begin
            case (ir_q)
                OP_IDENT:  dsel = DSEL_ID;
                OP_SAMPLE: dsel = DSEL_BSR;
                OP_EXTEST: begin dsel = DSEL_BSR; extest_en = 1'b1; end
                OP_FLOAT:  highz_en = 1'b1;
                default:   dsel = DSEL_BYPASS;
            endcase
        end
    end

    assign ir_lsb = ir_sr[0];

    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == CAP_PAT)); // R3
    AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q)); // R4
    AST_SECURE_NO_FLOAT: assert property (@(posedge tck) disable iff (!trst_n)
        secure_en |-> !highz_en); // R6

endmodule

// File: rtl/jtag_tap_dr.sv
// Bypass and identification data registers. Only the selected one captures
// and shifts. Assumes ID_VALUE fits ID_W bits.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h5A3C_96E5
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  dr_sel_t    dsel,
    output logic       byp_out,
    output logic       id_out
);
    logic            byp_q;
    logic [ID_W-1:0] id_sr;

    // Bypass bit: captures zero, then passes tdi with one stage of delay.
    always_ff @(posedge tck) begin
        if (!trst_n)                                          byp_q <= 1'b0;
        else if (dsel == DSEL_BYPASS && state == ST_CAP_DR)   byp_q <= 1'b0;
        else if (dsel == DSEL_BYPASS && state == ST_SH_DR)    byp_q <= tdi;
    end

    // Identification register: captures the device value, shifts LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                                    id_sr <= ID_VALUE;
        else if (dsel == DSEL_ID && state == ST_CAP_DR) id_sr <= ID_VALUE;
        else if (dsel == DSEL_ID && state == ST_SH_DR)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    assign byp_out = byp_q;
    assign id_out  = id_sr[0];

    AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (dsel == DSEL_BYPASS && state == ST_CAP_DR) |=> (byp_q == 1'b0)); // R8
    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        (dsel == DSEL_ID && state == ST_CAP_DR) |=> (id_sr == ID_VALUE)); // R9

endmodule

// File: rtl/jtag_tap_secure.sv
// Top of the test access port: controller, instruction path, internal data
// registers, boundary strobes and the falling-edge output stage.
// Assumes the boundary chain shifts on rising tck while bsr_shift is high.
module jtag_tap_secure
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h5A3C_96E5
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic secure_en,
    input  logic bsr_tdo,
    output logic tdo,
    output logic tdo_oe,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic extest_en,
    output logic highz_en
);
    tap_state_t state;
    dr_sel_t    dsel;
    logic       ir_lsb, byp_out, id_out;
    logic       dr_bit, tdo_q, oe_q;

    jtag_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    jtag_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .secure_en(secure_en), .ir_lsb(ir_lsb), .dsel(dsel),
        .highz_en(highz_en), .extest_en(extest_en)
    );

    jtag_tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .dsel(dsel), .byp_out(byp_out), .id_out(id_out)
    );

    // Boundary strobes follow the controller only for boundary instructions.
    always_comb begin
        bsr_capture = (dsel == DSEL_BSR) && (state == ST_CAP_DR);
        bsr_shift   = (dsel == DSEL_BSR) && (state == ST_SH_DR);
        bsr_update  = (dsel == DSEL_BSR) && (state == ST_UPD_DR);
    end

    // Serial bit of the selected data register.
    always_comb begin
        unique case (dsel)
            DSEL_ID:  dr_bit = id_out;
            DSEL_BSR: dr_bit = bsr_tdo;
            default:  dr_bit = byp_out;
        endcase
    end

    // Falling-edge output stage: value and enable for the tdo pad.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            tdo_q <= (state == ST_SH_IR) ? ir_lsb : dr_bit;
            oe_q  <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR)); // R7
    AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update})); // R11
    AST_EXTEST_BSR: assert property (@(posedge tck) disable iff (!trst_n)
        extest_en |-> !highz_en); // R11

endmodule

// File: tb/jtag_tap_secure_test.sv
module jtag_tap_secure_test;
    localparam logic [31:0] IDV = 32'h5A3C_96E5;

    logic tck = 1'b0;
    logic trst_n = 1'b0, tms = 1'b0, tdi = 1'b0, secure_en = 1'b0, bsr_tdo = 1'b0;
    logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, extest_en, highz_en;

    int n_vec = 0, n_bad = 0;
    logic s_tdo, s_oe, s_cap, s_sh, s_up;

    always #10 tck = ~tck;

    jtag_tap_secure uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .secure_en(secure_en),
        .bsr_tdo(bsr_tdo), .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update), .extest_en(extest_en),
        .highz_en(highz_en)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample outputs of the current state, then apply inputs for the next rising edge.
    task automatic step(input logic m, input logic d);
        @(negedge tck); #2;
        s_tdo = tdo; s_oe = tdo_oe; s_cap = bsr_capture; s_sh = bsr_shift; s_up = bsr_update;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    // From Run-Test/Idle: load a code, return the captured pattern, end in Run-Test/Idle.
    task automatic ir_scan(input logic [9:0] code, output logic [9:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 10; i++) begin
            step(i == 9, code[i]);
            cap[i] = s_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    // From Run-Test/Idle: 33-bit data scan with tdi high; counts strobes and enables.
    task automatic dr_scan(output logic [32:0] dat, output int nc, output int ns, output int nu, output int noe);
        nc = 0; ns = 0; nu = 0; noe = 0;
        for (int i = 0; i < 38; i++) begin
            if (i < 3)       step(i != 1 && i != 2 ? 1 : 0, 1);
            else if (i < 36) step(i == 35, 1);
            else             step(i == 36, 1);
            nc += s_cap; ns += s_sh; nu += s_up; noe += s_oe;
            if (i >= 3 && i < 36) dat[i-3] = s_tdo;
        end
    endtask

    function automatic int exp_sel(input logic [9:0] c, input logic sec);
        // 0 = bypass, 1 = identification, 2 = boundary
        if (c == 10'h006) return 1;
        if (c == 10'h005 || c == 10'h00F) return 2;
        return 0;
    endfunction

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] cap;
        logic [32:0] dat, exp_dat;
        int nc, ns, nu, noe, sel;
        bit ok;

        repeat (4) @(posedge tck);
        #1;
        @(negedge tck); #2; trst_n = 1'b1;
        @(posedge tck); #1;
        step(0, 0);
        // R1: reset state of outputs
        chk(!highz_en && !extest_en && !tdo_oe, "R1 reset outputs",
            {highz_en, extest_en, tdo_oe}, 3'b000);
        // R1 / R9: identification active after reset
        dr_scan(dat, nc, ns, nu, noe);
        chk(dat == {1'b1, IDV}, "R9 identification after reset", dat, {1'b1, IDV});
        chk(noe == 33, "R7 oe only in shift", noe, 33);

        // R7: tdo changes at falling edge only
        step(1, 0); step(0, 0); step(0, 0);
        @(negedge tck); #2;
        chk(tdo == IDV[0], "R7 first bit", tdo, IDV[0]);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        chk(tdo == IDV[0], "R7 holds across rising edge", tdo, IDV[0]);
        @(negedge tck); #2;
        chk(tdo == IDV[1], "R7 changes at falling edge", tdo, IDV[1]);
        step(1, 0); step(1, 0); step(0, 0);
        chk(!tdo_oe, "R7 oe low in idle", tdo_oe, 0);

        // R4: new code does not act before Update-IR
        ir_scan(10'h00F, cap);
        chk(extest_en, "R11 extest active", extest_en, 1);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 10; i++) step(i == 9, 10'h00B >> i);
        chk(extest_en && !highz_en, "R4 held until update", {extest_en, highz_en}, 2'b10);
        step(1, 0);
        chk(extest_en && !highz_en, "R4 held in Update-IR", {extest_en, highz_en}, 2'b10);
        step(0, 0);
        chk(!extest_en && highz_en, "R10 float active after update", {extest_en, highz_en}, 2'b01);

        // R2: five tms-high edges from Shift-DR restore identification
        ir_scan(10'h3FF, cap);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        dr_scan(dat, nc, ns, nu, noe);
        chk(dat == {1'b1, IDV}, "R2 identification after five ones", dat, {1'b1, IDV});

        // R3/R5/R6/R8/R9/R10/R11: every code, secure off then on
        for (int s = 0; s < 2; s++) begin
            secure_en = s[0];
            for (int c = 0; c < 1024; c++) begin
                ir_scan(c[9:0], cap);
                chk(cap == 10'h001, "R3 capture pattern", cap, 10'h001);
                sel = exp_sel(c[9:0], s[0]);
                chk(highz_en == (c == 'h00B && s == 0), "R6 R10 float request",
                    highz_en, (c == 'h00B && s == 0));
                chk(extest_en == (c == 'h00F), "R11 extest request", extest_en, (c == 'h00F));
                dr_scan(dat, nc, ns, nu, noe);
                if (sel == 1)      exp_dat = {1'b1, IDV};
                else if (sel == 2) exp_dat = 33'h0;
                else               exp_dat = {32'hFFFF_FFFF, 1'b0};
                chk(dat == exp_dat, "R5 R8 R9 selected register data", dat, exp_dat);
                ok = (sel == 2) ? (nc == 1 && ns == 33 && nu == 1) : (nc == 0 && ns == 0 && nu == 0);
                chk(ok, "R11 boundary strobes", {nc[15:0], ns[15:0], nu[15:0]},
                    (sel == 2) ? {16'd1, 16'd33, 16'd1} : 48'd0);
            end
        end

        // R1: synchronous reset from an arbitrary instruction
        secure_en = 0;
        ir_scan(10'h00B, cap);
        @(negedge tck); #2; trst_n = 0;
        @(posedge tck); #1;
        @(negedge tck); #2; trst_n = 1; tms = 0;
        @(posedge tck); #1;
        chk(!highz_en, "R1 float cleared by reset", highz_en, 0);
        dr_scan(dat, nc, ns, nu, noe);
        chk(dat == {1'b1, IDV}, "R1 identification after reset", dat, {1'b1, IDV});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule